// File: doc/BRIEF.md
# Chained Two-Channel Timebase

This block builds one wide free-running time base out of two narrow counter channels. The low channel counts ticks from a selectable prescaler on the system clock. Its square-wave output is high for the lower half of its count range and low for the upper half, so it rises once each time the low channel wraps. A routing selector can feed that square wave to the high channel as its clock. The high channel then counts one step for every full turn of the low channel. The selector can also feed a synchronised external pin to the high channel, or hold the high channel still.

The high channel does not count on a carry. It samples its selected clock input in the system clock domain and counts each rising edge it sees. For this reason the high half lags the low half by one clock at every wrap. Software reads the value in three steps: the high half, then the low half, then the high half again. If the two high reads differ, it reads again. A single sync command restarts the prescaler and both channels on the same clock edge.

Top module: `chained_timebase`

## Requirements
- R1: After reset both halves read zero and the low-channel waveform is high.
- R2: The low channel advances by one once every D system clocks, where div_sel values 0, 1, 2, 3 give D = 2, 8, 32, 128. The first advance after a sync comes D clocks after the sync edge.
- R3: The low channel wraps from its all-ones value to zero and keeps counting. Its width is CW bits, 16 by default.
- R4: The low-channel waveform is high while the low count is below half range and low from half range up to all ones. Half range is 0x8000 at the default width. The waveform rises when the count returns to zero.
- R5: With route_sel = 2'b10 the high channel advances by one on the clock edge after the low channel wraps to zero. The zero count that a sync sets does not cause an advance.
- R6: With route_sel = 2'b01 or 2'b11 the high channel keeps its value.
- R7: With route_sel = 2'b00 the high channel counts rising edges of ext_clk_pin. Each edge is counted three clocks after the pin is first sampled high.
- R8: A sync_all pulse clears both halves on the same edge and restarts the prescaler phase.
- R9: cnt_value holds the high half in its upper CW bits and the low half in its lower CW bits. During the single clock where the low half has wrapped but the high half has not yet advanced, a high-low-high read sees a mismatch and needs exactly one retry to get a coherent value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_all | input | 1 | One-cycle command that restarts every channel together |
| div_sel | input | 2 | Prescaler choice: 0 to 3 select divide by 2, 8, 32, 128 |
| route_sel | input | 2 | High-channel clock source: 00 pin, 10 low waveform, 01/11 hold |
| ext_clk_pin | input | 1 | Asynchronous external clock for the high channel |
| lo_wave | output | 1 | Low-channel half-range square wave |
| cnt_lo | output | CW | Low channel count |
| cnt_hi | output | CW | High channel count |
| cnt_value | output | 2*CW | Concatenated time value {cnt_hi, cnt_lo} |

## Verification
The chained mode is run with every prescaler ratio and with counts sampled at fixed distances from a sync. Samples just before and just after half range show whether the waveform compare is placed correctly. Samples on the wrap edge and one clock later show whether the high half advances at the right clock, and they expose the one-clock skew. A hold-mode run over the same wrap shows whether the routing selector really gates the chained clock. An external-pin run shows that the edge detector counts pin edges and not pin levels. A mid-run sync and a reader retry across a wrap check the restart and coherent-read rules.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // routing selector codes for the high channel clock input
  typedef enum logic [1:0] {
    SRC_PIN   = 2'b00,
    SRC_HOLD  = 2'b01,
    SRC_CHAIN = 2'b10,
    SRC_HOLD2 = 2'b11
  } hi_src_e;
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int NUM_DIV = 4,
  localparam int SW = $clog2(NUM_DIV),
  localparam int PW = 2 * NUM_DIV - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_all,
  input  logic [SW-1:0] div_sel,
  output logic          tick
);
  logic [PW-1:0] phase_q;
  logic [PW:0]   span;
  logic [PW-1:0] limit;

  // divisor for choice k is 2^(2k+1)
  always_comb begin
    span  = {{PW{1'b0}}, 1'b1} << (2 * int'(div_sel) + 1);
    limit = PW'(span - 1'b1);
  end

  // >= so that a smaller divisor chosen mid-count still wraps
  assign tick = (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || sync_all) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tbase_lo_chan.sv
module tbase_lo_chan #(
  parameter int CW = 16,
  localparam logic [CW-1:0] HALF = {1'b1, {(CW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_all,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          wave
);
  logic [CW-1:0] count_nxt;

  assign count_nxt = count + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || sync_all) begin
      count <= '0;
      wave  <= 1'b1;
    end else if (tick) begin
      count <= count_nxt;
      if (count_nxt == '0) begin
        wave <= 1'b1;
      end else if (count_nxt == HALF) begin
        wave <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tbase_route.sv
module tbase_route
  import tbase_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] route_sel,
  input  logic       ext_clk_pin,
  input  logic       lo_wave,
  output logic       hi_clk_in
);
  logic [SYNC_STAGES-1:0] sync_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= ext_clk_pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    case (hi_src_e'(route_sel))
      SRC_PIN:   hi_clk_in = sync_q[SYNC_STAGES-1];
      SRC_CHAIN: hi_clk_in = lo_wave;
      default:   hi_clk_in = 1'b0;
    endcase
  end
endmodule

// File: rtl/tbase_hi_chan.sv
module tbase_hi_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_all,
  input  logic          clk_in,
  output logic [CW-1:0] count
);
  logic prev_q;
  logic rise;

  assign rise = clk_in & ~prev_q;

  // prev forced high on restart so the zero-count level is not an edge
  always_ff @(posedge clk) begin
    if (rst || sync_all) begin
      prev_q <= 1'b1;
      count  <= '0;
    end else begin
      prev_q <= clk_in;
      if (rise) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/chained_timebase.sv
module chained_timebase #(
  parameter int CW          = 16,
  parameter int NUM_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SW = $clog2(NUM_DIV)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sync_all,
  input  logic [SW-1:0]   div_sel,
  input  logic [1:0]      route_sel,
  input  logic            ext_clk_pin,
  output logic            lo_wave,
  output logic [CW-1:0]   cnt_lo,
  output logic [CW-1:0]   cnt_hi,
  output logic [2*CW-1:0] cnt_value
);
  logic tick;
  logic hi_clk_in;

  tbase_prescaler #(.NUM_DIV(NUM_DIV)) u_pre (
    .clk(clk), .rst(rst), .sync_all(sync_all),
    .div_sel(div_sel), .tick(tick)
  );

  tbase_lo_chan #(.CW(CW)) u_lo (
    .clk(clk), .rst(rst), .sync_all(sync_all),
    .tick(tick), .count(cnt_lo), .wave(lo_wave)
  );

  tbase_route #(.SYNC_STAGES(SYNC_STAGES)) u_route (
    .clk(clk), .rst(rst), .route_sel(route_sel),
    .ext_clk_pin(ext_clk_pin), .lo_wave(lo_wave), .hi_clk_in(hi_clk_in)
  );

  tbase_hi_chan #(.CW(CW)) u_hi (
    .clk(clk), .rst(rst), .sync_all(sync_all),
    .clk_in(hi_clk_in), .count(cnt_hi)
  );

  assign cnt_value = {cnt_hi, cnt_lo};
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_all,
  input logic [1:0]    route_sel,
  input logic          lo_wave,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi
);
  localparam logic [CW-1:0] HALF = {1'b1, {(CW-1){1'b0}}};
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

  // R8
  sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sync_all |=> (cnt_lo == '0 && cnt_hi == '0));

  // R2
  lo_step_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_all |=> (cnt_lo == $past(cnt_lo) || cnt_lo == CW'($past(cnt_lo) + 1'b1)));

  // R2
  lo_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_lo != $past(cnt_lo) && !sync_all) |=> $stable(cnt_lo));

  // R4
  wave_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lo_wave) |-> cnt_lo == HALF);

  // R4
  wave_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_wave) |-> cnt_lo == '0);

  // R5
  chain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (route_sel == 2'b10 && $past(route_sel) == 2'b10 && !sync_all &&
     !$past(sync_all) && cnt_lo == '0 && $past(cnt_lo) == ALL1)
    |=> cnt_hi == CW'($past(cnt_hi) + 1'b1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (route_sel[0] && !sync_all) |=> cnt_hi == $past(cnt_hi));
endmodule

bind chained_timebase tbase_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .sync_all(sync_all), .route_sel(route_sel),
  .lo_wave(lo_wave), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
);

// File: tb/chained_timebase_bench.sv
module chained_timebase_bench;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sync_all = 1'b0;
  logic [1:0]    div_sel = 2'd0;
  logic [1:0]    route_sel = 2'b10;
  logic          ext_clk_pin = 1'b0;
  logic          lo_wave;
  logic [CW-1:0] cnt_lo;
  logic [CW-1:0] cnt_hi;
  logic [2*CW-1:0] cnt_value;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  chained_timebase #(.CW(CW)) u_chained_timebase (
    .clk(clk), .rst(rst), .sync_all(sync_all), .div_sel(div_sel),
    .route_sel(route_sel), .ext_clk_pin(ext_clk_pin), .lo_wave(lo_wave),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cnt_value(cnt_value)
  );

  // {route, div, clocks after sync, hi, lo, wave}
  localparam int NV = 12;
  localparam logic [36:0] VEC [NV] = '{
    {2'b10, 2'd0, 16'd0,     8'd0, 8'd0,   1'b1},
    {2'b10, 2'd0, 16'd1,     8'd0, 8'd0,   1'b1},
    {2'b10, 2'd0, 16'd2,     8'd0, 8'd1,   1'b1},
    {2'b10, 2'd0, 16'd255,   8'd0, 8'd127, 1'b1},
    {2'b10, 2'd0, 16'd256,   8'd0, 8'd128, 1'b0},
    {2'b10, 2'd0, 16'd510,   8'd0, 8'd255, 1'b0},
    {2'b10, 2'd0, 16'd512,   8'd0, 8'd0,   1'b1},
    {2'b10, 2'd0, 16'd513,   8'd1, 8'd0,   1'b1},
    {2'b10, 2'd1, 16'd2400,  8'd1, 8'd44,  1'b1},
    {2'b10, 2'd2, 16'd16385, 8'd2, 8'd0,   1'b1},
    {2'b10, 2'd3, 16'd25600, 8'd0, 8'd200, 1'b0},
    {2'b01, 2'd0, 16'd513,   8'd0, 8'd0,   1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sync sampled on one edge; returns at the falling edge after it
  task automatic do_sync();
    @(negedge clk) sync_all = 1'b1;
    @(negedge clk) sync_all = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20ns * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int hv, lv, h2, retries;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 lo after reset", cnt_lo, 0);
    check("R1 hi after reset", cnt_hi, 0);
    check("R1 wave after reset", lo_wave, 1);

    for (int i = 0; i < NV; i++) begin
      route_sel = VEC[i][36:35];
      div_sel   = VEC[i][34:33];
      do_sync();
      repeat (int'(VEC[i][32:17])) @(negedge clk);
      check($sformatf("R2 R3 vector %0d lo", i), cnt_lo, int'(VEC[i][8:1]));
      check($sformatf("%s vector %0d hi", VEC[i][35] ? "R5" : "R6", i),
            cnt_hi, int'(VEC[i][16:9]));
      check($sformatf("R4 vector %0d wave", i), lo_wave, int'(VEC[i][0]));
    end

    // R8 mid-run sync clears both halves on one edge
    route_sel = 2'b10; div_sel = 2'd0;
    do_sync();
    repeat (600) @(negedge clk);
    check("R8 hi before sync", cnt_hi, 1);
    do_sync();
    check("R8 lo after sync", cnt_lo, 0);
    check("R8 hi after sync", cnt_hi, 0);
    repeat (4) @(negedge clk);
    check("R8 prescaler phase restart", cnt_lo, 2);

    // R7 external pin edges
    route_sel = 2'b00; div_sel = 2'd3;
    do_sync();
    for (int p = 0; p < 5; p++) begin
      ext_clk_pin = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk_pin = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check("R7 pin edges counted", cnt_hi, 5);
    ext_clk_pin = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 level not counted", cnt_hi, 6);
    ext_clk_pin = 1'b0;

    // R9 coherent read across a wrap
    route_sel = 2'b10; div_sel = 2'd0;
    do_sync();
    repeat (511) @(negedge clk);
    retries = 0;
    hv = cnt_hi;
    @(negedge clk) lv = cnt_lo;
    @(negedge clk) h2 = cnt_hi;
    while (h2 != hv && retries < 4) begin
      retries++;
      hv = h2;
      @(negedge clk) lv = cnt_lo;
      @(negedge clk) h2 = cnt_hi;
    end
    check("R9 retry count", retries, 1);
    check("R9 coherent value", hv * 256 + lv, 257);
    check("R9 value concat", cnt_value, int'({cnt_hi, cnt_lo}));

    done = 1'b1;
    finish_run();
  end
endmodule